// File: doc/BRIEF.md
# Memory-Mapped Pin Bank with Atomic Set and Clear

This block owns a bank of general-purpose pins on a plain 32-bit register bus (address, write strobe, write data, read strobe, read data). Every pin has a direction bit and an output latch bit. Both are changed only through write-one-to-act registers. One register turns pins into outputs and another turns them back into inputs. A third raises output latches and a fourth lowers them. Software can therefore change any subset of pins with a single store, and a store never disturbs bits it does not name.

The bank drives a pad output vector and a pad output-enable vector straight from its own flops, and it samples the pad input vector. The pin-level view resynchronizes the raw pad inputs through a chain of flops. For a pin configured as an output, that view returns the output latch. Read data is registered. Interrupt detection, pulls and drive strength belong to other blocks.

Top module: `gpio_setclr_bank`

## Requirements
- R1: On synchronous active-high reset every pin becomes an input (pad_oe all 0), every output latch becomes 0 (pad_out all 0), and bus_rd_data is 0.
- R2: A write to byte offset 0x04 sets the direction bit of each pin whose write-data bit is 1, so that pad_oe is high after that clock edge; pins whose bit is 0 keep their direction.
- R3: A write to byte offset 0x08 clears the direction bit of each pin whose write-data bit is 1; pins whose bit is 0 keep their direction.
- R4: A read of byte offset 0x00 returns the direction vector, with bit n high when pin n is an output.
- R5: A write to byte offset 0x10 raises the output latch of each pin whose data bit is 1. A write to byte offset 0x14 lowers the output latch of each pin whose data bit is 1. Bits written as 0 leave their latches unchanged. pad_out shows the latch after the write edge.
- R6: A read of byte offset 0x10 returns the output latch vector.
- R7: A read of byte offset 0x0c returns, for output pins, the latch bit. For input pins it returns pad_in delayed through a two-flop synchronizer: a pad_in value present before clock edge k is returned by a read sampled at edge k+2, and a read sampled at edge k or k+1 returns the older value.
- R8: bus_rd_data is registered. It holds the selected value after the edge that samples bus_rd_en, and it is 0 after any edge where bus_rd_en was low.
- R9: Reads of any address other than 0x00, 0x0c and 0x10 return 0. This includes the write-only offsets 0x04, 0x08 and 0x14 and addresses that are not word aligned.
- R10: Writes to the read-only offsets 0x00 and 0x0c and to unmapped addresses change neither pad_oe nor pad_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one access per cycle |
| bus_wr_data | input | PINS (32) | Write data, one bit per pin |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | PINS (32) | Registered read data |
| pad_in | input | PINS (32) | Asynchronous pad input levels |
| pad_out | output | PINS (32) | Output latch, driven to the pads |
| pad_oe | output | PINS (32) | Output enable per pin, high for output |

## Verification
The direction and latch flops drive pad_oe and pad_out directly. A wrong bit in either therefore shows on the pads in the cycle after the offending write, and a read of offset 0x00 or 0x10 shows it again one cycle after the read strobe. A wrong decode shows up as a changed pad vector after a write to a read-only or unmapped offset, or as nonzero data from a write-only offset. An error in synchronizer depth moves the first cycle in which a new pad level appears at offset 0x0c by one edge, so the bench reads every cycle across that window.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  // Byte offsets of the register windows.
  localparam int unsigned OFS_DIR   = 32'h00;
  localparam int unsigned OFS_MKOUT = 32'h04;
  localparam int unsigned OFS_MKIN  = 32'h08;
  localparam int unsigned OFS_LEVEL = 32'h0c;
  localparam int unsigned OFS_SET   = 32'h10;
  localparam int unsigned OFS_CLR   = 32'h14;

  typedef struct packed {
    logic dir_out;
    logic dir_in;
    logic lat_set;
    logic lat_clr;
  } wr_sel_t;

  typedef enum logic [1:0] {
    RSRC_NONE  = 2'd0,
    RSRC_DIR   = 2'd1,
    RSRC_LEVEL = 2'd2,
    RSRC_LATCH = 2'd3
  } rd_src_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_setclr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output wr_sel_t           wr_sel,
  output rd_src_t           rd_src
);

  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_MKOUT = ADDR_W'(OFS_MKOUT);
  localparam logic [ADDR_W-1:0] A_MKIN  = ADDR_W'(OFS_MKIN);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);

  // Only the four action windows accept writes.
  always_comb begin
    wr_sel.dir_out = wr_en && (addr == A_MKOUT);
    wr_sel.dir_in  = wr_en && (addr == A_MKIN);
    wr_sel.lat_set = wr_en && (addr == A_SET);
    wr_sel.lat_clr = wr_en && (addr == A_CLR);
  end

  // Only three windows return data; anything else reads as zero.
  always_comb begin
    rd_src = RSRC_NONE;
    if (rd_en) begin
      if (addr == A_DIR)        rd_src = RSRC_DIR;
      else if (addr == A_LEVEL) rd_src = RSRC_LEVEL;
      else if (addr == A_SET)   rd_src = RSRC_LATCH;
      else                      rd_src = RSRC_NONE;
    end
  end

endmodule

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);

  // Set and clear never arrive together (one address per access);
  // set is given priority so the logic stays a simple two-level mux.
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [PINS-1:0]   bus_wr_data,
  input  logic              bus_rd_en,
  output logic [PINS-1:0]   bus_rd_data,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);

  wr_sel_t         wr_sel;
  rd_src_t         rd_src;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] lat_q;
  logic [PINS-1:0] in_sync;
  logic [PINS-1:0] level;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr_en  (bus_wr_en),
    .rd_en  (bus_rd_en),
    .wr_sel (wr_sel),
    .rd_src (rd_src)
  );

  gpio_sc_reg #(.W(PINS)) u_dir (
    .clk    (clk),
    .rst    (rst),
    .set_en (wr_sel.dir_out),
    .clr_en (wr_sel.dir_in),
    .mask   (bus_wr_data),
    .q      (dir_q)
  );

  gpio_sc_reg #(.W(PINS)) u_lat (
    .clk    (clk),
    .rst    (rst),
    .set_en (wr_sel.lat_set),
    .clr_en (wr_sel.lat_clr),
    .mask   (bus_wr_data),
    .q      (lat_q)
  );

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (in_sync)
  );

  // Output pins report what they drive, input pins what they see.
  assign level = (dir_q & lat_q) | (~dir_q & in_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd_data <= '0;
    end else begin
      case (rd_src)
        RSRC_DIR:   bus_rd_data <= dir_q;
        RSRC_LEVEL: bus_rd_data <= level;
        RSRC_LATCH: bus_rd_data <= lat_q;
        default:    bus_rd_data <= '0;
      endcase
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = lat_q;

endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk
  import gpio_setclr_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [PINS-1:0]   bus_wr_data,
  input logic              bus_rd_en,
  input logic [PINS-1:0]   bus_rd_data,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe
);

  localparam logic [ADDR_W-1:0] C_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] C_MKOUT = ADDR_W'(OFS_MKOUT);
  localparam logic [ADDR_W-1:0] C_MKIN  = ADDR_W'(OFS_MKIN);
  localparam logic [ADDR_W-1:0] C_LEVEL = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] C_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] C_CLR   = ADDR_W'(OFS_CLR);

  logic rd_mapped;
  logic wr_action;
  assign rd_mapped = (bus_addr == C_DIR) || (bus_addr == C_LEVEL) || (bus_addr == C_SET);
  assign wr_action = (bus_addr == C_MKOUT) || (bus_addr == C_MKIN) ||
                     (bus_addr == C_SET)   || (bus_addr == C_CLR);

  assert_mkout_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == C_MKOUT) |=> pad_oe == ($past(pad_oe) | $past(bus_wr_data)));

  assert_mkin_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == C_MKIN) |=> pad_oe == ($past(pad_oe) & ~$past(bus_wr_data)));

  assert_dir_read_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == C_DIR) |=> bus_rd_data == $past(pad_oe));

  assert_latch_set_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == C_SET) |=> pad_out == ($past(pad_out) | $past(bus_wr_data)));

  assert_latch_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == C_CLR) |=> pad_out == ($past(pad_out) & ~$past(bus_wr_data)));

  assert_latch_read_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == C_SET) |=> bus_rd_data == $past(pad_out));

  assert_level_outpins_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == C_LEVEL) |=>
      (bus_rd_data & $past(pad_oe)) == ($past(pad_out) & $past(pad_oe)));

  assert_idle_read_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> bus_rd_data == '0);

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !rd_mapped) |=> bus_rd_data == '0);

  assert_ignored_write_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_en && wr_action) |=> $stable(pad_oe) && $stable(pad_out));

endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr_en   (bus_wr_en),
  .bus_wr_data (bus_wr_data),
  .bus_rd_en   (bus_rd_en),
  .bus_rd_data (bus_rd_data),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe)
);

// File: tb/gpio_setclr_bank_bench.sv
module gpio_setclr_bank_bench;

  localparam int PINS   = 32;
  localparam int ADDR_W = 6;

  // Vector: {op[1:0], addr[7:0], a[31:0], b[31:0]}
  // op 0: write a to addr; op 1: read addr, expect b; op 2: expect pad_oe=a, pad_out=b
  localparam int NV = 25;
  localparam logic [31:0] PIN_PAT = 32'hA5A5_0F0F;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h04, 32'h0000_00FF, 32'h0},           // R2
    {2'd1, 8'h00, 32'h0, 32'h0000_00FF},           // R4
    {2'd0, 8'h04, 32'h0000_0F00, 32'h0},           // R2 zero bits kept
    {2'd0, 8'h08, 32'h0000_000F, 32'h0},           // R3
    {2'd1, 8'h00, 32'h0, 32'h0000_0FF0},           // R3 R4
    {2'd0, 8'h10, 32'h1234_5678, 32'h0},           // R5 set
    {2'd0, 8'h14, 32'h0000_0070, 32'h0},           // R5 clear
    {2'd1, 8'h10, 32'h0, 32'h1234_5608},           // R6
    {2'd2, 8'h00, 32'h0000_0FF0, 32'h1234_5608},   // R5 pads
    {2'd1, 8'h0c, 32'h0, 32'hA5A5_060F},           // R7 mixed
    {2'd1, 8'h04, 32'h0, 32'h0},                   // R9 write-only
    {2'd1, 8'h14, 32'h0, 32'h0},                   // R9 write-only
    {2'd0, 8'h00, 32'hFFFF_FFFF, 32'h0},           // R10 read-only
    {2'd0, 8'h0c, 32'hFFFF_FFFF, 32'h0},           // R10 read-only
    {2'd0, 8'h3c, 32'hFFFF_FFFF, 32'h0},           // R10 unmapped
    {2'd2, 8'h00, 32'h0000_0FF0, 32'h1234_5608},   // R10 pads unchanged
    {2'd1, 8'h3c, 32'h0, 32'h0},                   // R9 unmapped
    {2'd0, 8'h10, 32'h0000_0000, 32'h0},           // R5 all-zero set
    {2'd0, 8'h08, 32'hFFFF_FFFF, 32'h0},           // R3 all inputs
    {2'd1, 8'h0c, 32'h0, 32'hA5A5_0F0F},           // R7 all inputs
    {2'd0, 8'h04, 32'hFFFF_FFFF, 32'h0},           // R2 all outputs
    {2'd1, 8'h0c, 32'h0, 32'h1234_5608},           // R7 all outputs
    {2'd0, 8'h14, 32'hFFFF_FFFF, 32'h0},           // R5 clear all
    {2'd2, 8'h00, 32'hFFFF_FFFF, 32'h0},           // R5 R2 pads
    {2'd1, 8'h01, 32'h0, 32'h0}                    // R9 misaligned
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [PINS-1:0]   bus_wr_data = '0;
  logic              bus_rd_en = 1'b0;
  logic [PINS-1:0]   bus_rd_data;
  logic [PINS-1:0]   pad_in = '0;
  logic [PINS-1:0]   pad_out;
  logic [PINS-1:0]   pad_oe;

  int  n_checks = 0;
  int  n_bad    = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  gpio_setclr_bank #(.PINS(PINS), .ADDR_W(ADDR_W)) u_gpio_setclr_bank (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[ADDR_W-1:0]; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wr_data = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a[ADDR_W-1:0]; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    pad_in = PIN_PAT;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 rd_data", bus_rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        2'd0: bus_write(VEC[i][71:64], VEC[i][63:32]);
        2'd1: begin
          bus_read(VEC[i][71:64], rv);
          check($sformatf("R4/R6/R7/R9 vec%0d", i), rv, VEC[i][31:0]);
        end
        default: begin
          @(negedge clk);
          check($sformatf("R2/R3 oe vec%0d", i), pad_oe, VEC[i][63:32]);
          check($sformatf("R5/R10 out vec%0d", i), pad_out, VEC[i][31:0]);
        end
      endcase
    end

    // R7 synchronizer latency: all inputs, change pad_in and read every cycle
    bus_write(8'h08, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    pad_in = 32'h5A5A_F0F0;
    bus_addr = 6'h0c; bus_rd_en = 1'b1;
    @(negedge clk);
    check("R7 edge k old", bus_rd_data, PIN_PAT);
    @(negedge clk);
    check("R7 edge k+1 old", bus_rd_data, PIN_PAT);
    @(negedge clk);
    check("R7 edge k+2 new", bus_rd_data, 32'h5A5A_F0F0);
    bus_rd_en = 1'b0;
    @(negedge clk);
    check("R8 idle read zero", bus_rd_data, 32'h0);

    // R1 reset from a loaded state
    bus_write(8'h04, 32'hF0F0_0001);
    bus_write(8'h10, 32'h8000_0003);
    @(negedge clk);
    check("R2 before reset", pad_oe, 32'hF0F0_0001);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 oe after reset", pad_oe, 32'h0);
    check("R1 out after reset", pad_out, 32'h0);
    bus_read(8'h10, rv);
    check("R1 R6 latch after reset", rv, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule